// File: doc/BRIEF.md
# System control coprocessor register file

This block holds the memory-management control state of a processor core and is reached through coprocessor move instructions. The core presents the 32-bit instruction word together with write data and a write strobe. The block splits the word into a primary register number, two opcode fields and a secondary register number. It then either updates one stored register on the next rising clock edge or returns that register's value on a combinational read path. Several registers share one primary number and are told apart by the second opcode field. Some fields are narrowed when written, and the system control word has bits that are pinned high or low.

The stored translation settings leave the block on dedicated outputs, which the page table walker uses without any access cycle. These settings are the control word, both table base words, the table-split width, the domain access word and the context identifier. Identification words are constants, and the instruction fault status comes in from the fault logic as an input. Cache maintenance, TLB maintenance and lockdown numbers are decoded but change nothing and read back as zero.

The access port is a plain register port with no valid/ready pair. A write completes in the cycle its strobe is sampled, and a read is valid in the same cycle the instruction word is presented, so there is no back-pressure to manage.

Top module: `scp_regfile`

## Requirements
- R1: The primary register number is taken from instruction bits [19:16], the first opcode from [23:21], the secondary register number from [3:0] and the second opcode from [7:5]. A register is selected only when the first opcode and the secondary number are both zero; any other value reads zero and a write to it has no effect.
- R2: The system control word (primary 1, second opcode 0) resets to 32'h0005_0078. Every write stores the data with bits 6:3, 16 and 18 set to one and bit 10 cleared, and every read shows the same forcing.
- R3: Primary 1 with second opcode 1 is an auxiliary control word and with second opcode 2 a coprocessor access word. Both are 32 bits, written and read in full.
- R4: Primary 2 with second opcode 0 and 1 selects the two 32-bit table base words. Second opcode 2 selects the table-split width, of which only data bits [2:0] are kept; the upper bits read as zero.
- R5: Primary 0 with second opcode 0 reads the CPU_ID parameter, and with second opcode 1 reads the constant 32'h0D17_2172. Writes to either change nothing.
- R6: Primary 5 with second opcode 0 is the data fault status, which keeps only data bits [7:0]. Second opcode 1 reads the ifsr_i input, and writes to it are ignored.
- R7: Primary 3 is the 32-bit domain access word and primary 6 the 32-bit fault address word, each selected for any second opcode.
- R8: Primary 13 selects by second opcode: 0 is the process identifier, 1 the context identifier and 3 the user read-only thread identifier, each 32 bits.
- R9: Every other combination reads zero and a write to it changes no register. This includes primaries 7 to 10, which carry cache and TLB maintenance and lockdown.
- R10: A write takes effect on the rising clock edge where wr_en_i is high. Reads are combinational from the current stored values. All words other than the control word reset to zero.
- R11: The walker outputs always carry the stored control word, both table bases, the split width, the domain access word and the context identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Coprocessor instruction word |
| wr_en_i | input | 1 | Write strobe for the selected register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register |
| ifsr_i | input | 32 | Instruction fault status from the fault logic |
| ctrl_o | output | 32 | System control word to the walker |
| ttb0_o | output | 32 | First table base word |
| ttb1_o | output | 32 | Second table base word |
| split_o | output | 3 | Table-split width |
| dacr_o | output | 32 | Domain access word |
| ctx_id_o | output | 32 | Context identifier |

## Verification
The assertions assume that the instruction word and write data are stable across the sampling edge whenever wr_en_i is high, and that a stored word changes only through a write strobe. The stimulus changes instr_i, wdata_i and wr_en_i only on falling edges and raises the strobe for exactly one cycle per write. It reads only while the strobe is low, so every read sees settled state and never races a write.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int unsigned DW       = 32;
  localparam int unsigned SPLIT_W  = 3;
  localparam int unsigned DFSR_W   = 8;

  localparam logic [DW-1:0] CTRL_SET   = 32'h0005_0078;
  localparam logic [DW-1:0] CTRL_CLR   = 32'h0000_0400;
  localparam logic [DW-1:0] CTRL_RST   = CTRL_SET;
  localparam logic [DW-1:0] CACHE_TYPE = 32'h0D17_2172;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_CTYPE, SEL_CTRL, SEL_AUX, SEL_CPACC,
    SEL_TTB0, SEL_TTB1, SEL_SPLIT, SEL_DACR, SEL_DFSR, SEL_IFSR,
    SEL_FAR, SEL_PID, SEL_CTX, SEL_TID
  } sel_e;

  typedef struct packed {
    logic [DW-1:0]      ctrl;
    logic [DW-1:0]      aux;
    logic [DW-1:0]      cpacc;
    logic [DW-1:0]      ttb0;
    logic [DW-1:0]      ttb1;
    logic [SPLIT_W-1:0] split;
    logic [DW-1:0]      dacr;
    logic [DFSR_W-1:0]  dfsr;
    logic [DW-1:0]      far;
    logic [DW-1:0]      pid;
    logic [DW-1:0]      ctx;
    logic [DW-1:0]      tid;
  } regs_t;

  function automatic logic [DW-1:0] pin_ctrl(input logic [DW-1:0] v);
    return (v | CTRL_SET) & ~CTRL_CLR;
  endfunction

endpackage

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
(
  input  logic [DW-1:0] instr,
  output sel_e          sel
);
  logic [3:0] crn;
  logic [2:0] opc1;
  logic [3:0] crm;
  logic [2:0] opc2;
  logic       unused_bits;

  assign crn  = instr[19:16];
  assign opc1 = instr[23:21];
  assign crm  = instr[3:0];
  assign opc2 = instr[7:5];
  assign unused_bits = ^{instr[31:24], instr[20], instr[15:8], instr[4]};

  always_comb begin
    sel = SEL_NONE;
    if (opc1 == 3'd0 && crm == 4'd0) begin
      unique case (crn)
        4'd0: begin
          if (opc2 == 3'd0)      sel = SEL_ID;
          else if (opc2 == 3'd1) sel = SEL_CTYPE;
        end
        4'd1: begin
          if (opc2 == 3'd0)      sel = SEL_CTRL;
          else if (opc2 == 3'd1) sel = SEL_AUX;
          else if (opc2 == 3'd2) sel = SEL_CPACC;
        end
        4'd2: begin
          if (opc2 == 3'd0)      sel = SEL_TTB0;
          else if (opc2 == 3'd1) sel = SEL_TTB1;
          else if (opc2 == 3'd2) sel = SEL_SPLIT;
        end
        4'd3: sel = SEL_DACR;
        4'd5: begin
          if (opc2 == 3'd0)      sel = SEL_DFSR;
          else if (opc2 == 3'd1) sel = SEL_IFSR;
        end
        4'd6: sel = SEL_FAR;
        4'd13: begin
          if (opc2 == 3'd0)      sel = SEL_PID;
          else if (opc2 == 3'd1) sel = SEL_CTX;
          else if (opc2 == 3'd3) sel = SEL_TID;
        end
        default: sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/scp_regbank.sv
module scp_regbank
  import scp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  sel_e          sel,
  input  logic [DW-1:0] wdata,
  output regs_t         regs_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_q      <= '0;
      regs_q.ctrl <= CTRL_RST;
    end else if (wr_en) begin
      unique case (sel)
        SEL_CTRL:  regs_q.ctrl  <= pin_ctrl(wdata);
        SEL_AUX:   regs_q.aux   <= wdata;
        SEL_CPACC: regs_q.cpacc <= wdata;
        SEL_TTB0:  regs_q.ttb0  <= wdata;
        SEL_TTB1:  regs_q.ttb1  <= wdata;
        SEL_SPLIT: regs_q.split <= wdata[SPLIT_W-1:0];
        SEL_DACR:  regs_q.dacr  <= wdata;
        SEL_DFSR:  regs_q.dfsr  <= wdata[DFSR_W-1:0];
        SEL_FAR:   regs_q.far   <= wdata;
        SEL_PID:   regs_q.pid   <= wdata;
        SEL_CTX:   regs_q.ctx   <= wdata;
        SEL_TID:   regs_q.tid   <= wdata;
        default: ;
      endcase
    end
  end

  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_CTRL) |=> $stable(regs_q.ctrl));

  p_ctrl_pinned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_CTRL) |=>
      (regs_q.ctrl[6:3] == 4'hF && regs_q.ctrl[16] && regs_q.ctrl[18] && !regs_q.ctrl[10]));

  p_split_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_SPLIT) |=> regs_q.split == $past(wdata[SPLIT_W-1:0]));

  p_dfsr_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DFSR) |=> regs_q.dfsr == $past(wdata[DFSR_W-1:0]));

  p_none_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |=> $stable(regs_q));

endmodule

// File: rtl/scp_readmux.sv
module scp_readmux
  import scp_pkg::*;
#(
  parameter logic [DW-1:0] CPU_ID = 32'h5A00_1234
)(
  input  sel_e          sel,
  input  regs_t         regs_q,
  input  logic [DW-1:0] ifsr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned SPLIT_PAD = DW - SPLIT_W;
  localparam int unsigned DFSR_PAD  = DW - DFSR_W;

  always_comb begin
    unique case (sel)
      SEL_ID:    rdata = CPU_ID;
      SEL_CTYPE: rdata = CACHE_TYPE;
      SEL_CTRL:  rdata = pin_ctrl(regs_q.ctrl);
      SEL_AUX:   rdata = regs_q.aux;
      SEL_CPACC: rdata = regs_q.cpacc;
      SEL_TTB0:  rdata = regs_q.ttb0;
      SEL_TTB1:  rdata = regs_q.ttb1;
      SEL_SPLIT: rdata = {{SPLIT_PAD{1'b0}}, regs_q.split};
      SEL_DACR:  rdata = regs_q.dacr;
      SEL_DFSR:  rdata = {{DFSR_PAD{1'b0}}, regs_q.dfsr};
      SEL_IFSR:  rdata = ifsr;
      SEL_FAR:   rdata = regs_q.far;
      SEL_PID:   rdata = regs_q.pid;
      SEL_CTX:   rdata = regs_q.ctx;
      SEL_TID:   rdata = regs_q.tid;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
  import scp_pkg::*;
#(
  parameter logic [31:0] CPU_ID = 32'h5A00_1234
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] instr_i,
  input  logic        wr_en_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [31:0] ifsr_i,
  output logic [31:0] ctrl_o,
  output logic [31:0] ttb0_o,
  output logic [31:0] ttb1_o,
  output logic [2:0]  split_o,
  output logic [31:0] dacr_o,
  output logic [31:0] ctx_id_o
);
  sel_e  sel;
  regs_t regs_q;

  scp_decode u_decode (
    .instr (instr_i),
    .sel   (sel)
  );

  scp_regbank u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en_i),
    .sel    (sel),
    .wdata  (wdata_i),
    .regs_q (regs_q)
  );

  scp_readmux #(.CPU_ID(CPU_ID)) u_rmux (
    .sel    (sel),
    .regs_q (regs_q),
    .ifsr   (ifsr_i),
    .rdata  (rdata_o)
  );

  assign ctrl_o   = regs_q.ctrl;
  assign ttb0_o   = regs_q.ttb0;
  assign ttb1_o   = regs_q.ttb1;
  assign split_o  = regs_q.split;
  assign dacr_o   = regs_q.dacr;
  assign ctx_id_o = regs_q.ctx;

  p_opc1_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_i[23:21] != 3'd0) |-> rdata_o == 32'd0);

  p_ttb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && instr_i[19:16] == 4'd2) |=> ($stable(ttb0_o) && $stable(ttb1_o)));

  p_id_const_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_i[23:21] == 3'd0 && instr_i[3:0] == 4'd0 && instr_i[19:16] == 4'd0 &&
     instr_i[7:5] == 3'd1) |-> rdata_o == CACHE_TYPE);

endmodule

// File: tb/scp_regfile_tb.sv
module scp_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CPU_ID = 32'h5A00_1234;
  localparam logic [31:0] IFSR_V = 32'hCAFE_0013;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] ifsr_i = IFSR_V;
  logic [31:0] ctrl_o, ttb0_o, ttb1_o, dacr_o, ctx_id_o;
  logic [2:0]  split_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_ctrl, m_aux, m_cp, m_t0, m_t1, m_dacr, m_far, m_pid, m_ctx, m_tid;
  logic [2:0]  m_split;
  logic [7:0]  m_dfsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  scp_regfile #(.CPU_ID(CPU_ID)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ifsr_i(ifsr_i), .ctrl_o(ctrl_o),
    .ttb0_o(ttb0_o), .ttb1_o(ttb1_o), .split_o(split_o), .dacr_o(dacr_o),
    .ctx_id_o(ctx_id_o)
  );

  function automatic logic [31:0] mk(int crn, int opc1, int crm, int opc2);
    return {8'h0E, opc1[2:0], 1'b1, crn[3:0], 8'h0F, opc2[2:0], 1'b1, crm[3:0]};
  endfunction

  function automatic logic [31:0] pinned(logic [31:0] v);
    return (v | 32'h0005_0078) & ~32'h0000_0400;
  endfunction

  function automatic string req_of(int crn, int opc2);
    case (crn)
      0: return "R5";
      1: return (opc2 == 0) ? "R2" : "R3";
      2: return "R4";
      3, 6: return "R7";
      5: return "R6";
      13: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] exp_read(int crn, int opc2);
    case (crn)
      0: return (opc2 == 0) ? CPU_ID : (opc2 == 1) ? 32'h0D17_2172 : 32'd0;
      1: return (opc2 == 0) ? pinned(m_ctrl) : (opc2 == 1) ? m_aux : (opc2 == 2) ? m_cp : 32'd0;
      2: return (opc2 == 0) ? m_t0 : (opc2 == 1) ? m_t1 : (opc2 == 2) ? {29'd0, m_split} : 32'd0;
      3: return m_dacr;
      5: return (opc2 == 0) ? {24'd0, m_dfsr} : (opc2 == 1) ? IFSR_V : 32'd0;
      6: return m_far;
      13: return (opc2 == 0) ? m_pid : (opc2 == 1) ? m_ctx : (opc2 == 3) ? m_tid : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_write(int crn, int opc2, logic [31:0] w);
    case (crn)
      1: if (opc2 == 0) m_ctrl = pinned(w); else if (opc2 == 1) m_aux = w; else if (opc2 == 2) m_cp = w;
      2: if (opc2 == 0) m_t0 = w; else if (opc2 == 1) m_t1 = w; else if (opc2 == 2) m_split = w[2:0];
      3: m_dacr = w;
      5: if (opc2 == 0) m_dfsr = w[7:0];
      6: m_far = w;
      13: if (opc2 == 0) m_pid = w; else if (opc2 == 1) m_ctx = w; else if (opc2 == 3) m_tid = w;
      default: ;
    endcase
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(logic [31:0] ins, logic [31:0] w);
    @(negedge clk);
    instr_i = ins; wdata_i = w; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic read_check(int crn, int opc2);
    instr_i = mk(crn, 0, 0, opc2);
    #1;
    check(req_of(crn, opc2), $sformatf("read crn=%0d opc2=%0d", crn, opc2),
          rdata_o, exp_read(crn, opc2));
  endtask

  task automatic walker_check();
    check("R11", "walker ctrl", ctrl_o, m_ctrl);
    check("R11", "walker ttb0", ttb0_o, m_t0);
    check("R11", "walker ttb1", ttb1_o, m_t1);
    check("R11", "walker split", {29'd0, split_o}, {29'd0, m_split});
    check("R11", "walker dacr", dacr_o, m_dacr);
    check("R11", "walker ctx", ctx_id_o, m_ctx);
  endtask

  task automatic full_readback();
    for (int c = 0; c < 16; c++)
      for (int o = 0; o < 8; o++)
        read_check(c, o);
  endtask

  initial begin
    m_ctrl = 32'h0005_0078;
    m_aux = '0; m_cp = '0; m_t0 = '0; m_t1 = '0; m_dacr = '0;
    m_far = '0; m_pid = '0; m_ctx = '0; m_tid = '0; m_split = '0; m_dfsr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 and R2: reset state
    check("R2", "ctrl after reset", ctrl_o, 32'h0005_0078);
    full_readback();
    walker_check();

    for (int p = 0; p < 4; p++) begin
      logic [31:0] pat;
      pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0000_0000 :
            (p == 2) ? 32'hA5A5_5A5A : 32'h1234_5678;
      // R1..R9: write each address of the map, read it back
      for (int c = 0; c < 16; c++) begin
        for (int o = 0; o < 8; o++) begin
          logic [31:0] w;
          w = pat ^ {16'd0, 4'(c), 5'd0, 3'(o), 4'd0};
          do_write(mk(c, 0, 0, o), w);
          model_write(c, o, w);
          read_check(c, o);
          walker_check();
        end
      end
      // R1: nonzero opc1 or CRm selects nothing; writes ignored
      for (int c = 0; c < 16; c++) begin
        for (int o = 0; o < 8; o++) begin
          int op1 = 1 + ((c + o) % 7);
          int cm  = 1 + ((c * 3 + o) % 15);
          do_write(mk(c, op1, 0, o), ~pat);
          instr_i = mk(c, op1, 0, o); #1;
          check("R1", "opc1 nonzero reads zero", rdata_o, 32'd0);
          do_write(mk(c, 0, cm, o), ~pat);
          instr_i = mk(c, 0, cm, o); #1;
          check("R1", "crm nonzero reads zero", rdata_o, 32'd0);
        end
      end
      full_readback();
      walker_check();
    end

    // R6: instruction fault status follows the input
    @(negedge clk);
    ifsr_i = 32'h0BAD_F00D;
    instr_i = mk(5, 0, 0, 1); #1;
    check("R6", "ifsr follows input", rdata_o, 32'h0BAD_F00D);

    // R10: reset restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    ifsr_i = IFSR_V;
    m_ctrl = 32'h0005_0078;
    m_aux = '0; m_cp = '0; m_t0 = '0; m_t1 = '0; m_dacr = '0;
    m_far = '0; m_pid = '0; m_ctx = '0; m_tid = '0; m_split = '0; m_dfsr = '0;
    full_readback();
    walker_check();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule